// File: doc/BRIEF.md
# Double-Buffered Scanout Address Latch

This block keeps the surface base addresses for one display pipe. Each address has a staged copy and an active copy. Software writes the staged copies one 32-bit half at a time through a simple write port, and can read them back through a combinational read port. The active copies drive the scanout fetch logic. They change only at the start of vertical blank, so a frame is never fetched from two different surfaces.

There are two 64-bit addresses. The primary address is used for normal scanout. The secondary address is used for single-pipe stereo and follows the same double-buffering rule. Writing the low half of the primary address arms an update. The arm raises a pending status bit. At the next rising edge of the vertical-blank level, both staged addresses are copied into the active registers and the pending bit drops. A lock bit in the control register holds the copy back. While the lock is set, the pending bit stays visible, and the copy waits for the first vertical-blank start after the lock clears.

Top module: `scanout_addr_latch`

## Requirements
- R1: After reset, both active addresses, all staged halves, the lock bit and the pending bit are zero.
- R2: A write to the primary high half (offset 1) or to either secondary half (offsets 2 and 3) only stages data. Pending does not rise, and the active addresses do not change.
- R3: A write to the primary low half (offset 0) sets pending in the cycle after the write. Pending is visible on `update_pending` and as bit 1 of the control register (offset 4).
- R4: On the first clock where `vblank` is high after being low, if pending is set and the lock is clear, the active primary address loads {staged high, staged low} and pending clears. Both take effect on that same clock edge.
- R5: Outside such a transfer, the active addresses hold their value on every clock.
- R6: The active secondary address loads {staged secondary high, staged secondary low} in the same transfer as the primary.
- R7: While the lock (control bit 0) is set, no transfer occurs and pending stays set. Clearing the lock causes no transfer by itself. The transfer happens at the first vblank rising edge after the lock is cleared.
- R8: Several primary-low writes made while an update is pending leave a single transfer of the newest staged values. A later vblank edge with nothing pending changes nothing.
- R9: Reading offsets 0 to 3 returns the staged half last written there. Reading offset 4 returns {pending, lock} in bits 1 and 0, with the other bits zero.
- R10: Reading an unmapped offset (5 to 7) returns zero.
- R11: `vblank` is a level signal. Holding it high causes at most one transfer. An update armed while it stays high waits for its next rising edge.
- R12: If a primary-low write lands on the same clock as an eligible vblank edge, the values staged before that write are transferred, and pending stays set for the new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word offset |
| rd_data | output | 32 | Read data (combinational) |
| vblank | input | 1 | Vertical-blank level from the timing generator |
| pri_addr | output | 64 | Active primary surface address |
| sec_addr | output | 64 | Active secondary surface address |
| update_pending | output | 1 | Armed update not yet applied |

## Verification
The bench targets the timing corners of the transfer.

- **Lock released between edges.** A design that treated the release itself as a transfer trigger would update mid-frame.
- **Update armed while `vblank` is already high.** A level-triggered latch would apply it at once instead of at the next edge.
- **Repeated low writes before a vblank.** A design that queued them would transfer twice, or would transfer stale halves.
- **Arm on the same clock as an edge.** A wrong priority would either lose the new arm or load the newly written half early.

A behavioural model runs in parallel and compares both active addresses, the pending bit and the read data on every cycle.

// File: rtl/sal_pkg.sv
package sal_pkg;
  // Word offsets of the register map; the bench and software depend on these.
  localparam int OFS_PRI_LO = 0;
  localparam int OFS_PRI_HI = 1;
  localparam int OFS_SEC_LO = 2;
  localparam int OFS_SEC_HI = 3;
  localparam int OFS_CTRL   = 4;
  localparam int NUM_SURF   = 2;   // primary, secondary
  // Control word bit positions
  localparam int CTRL_LOCK_BIT = 0;
  localparam int CTRL_PEND_BIT = 1;
endpackage

// File: rtl/sal_vblank_edge.sv
module sal_vblank_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic vblank,
  output logic vb_rise
);
  logic vb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vb_q <= 1'b0;
    else        vb_q <= vblank;
  end

  assign vb_rise = vblank & ~vb_q;

  // A level held high yields a single-cycle event.
  assert_single_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vb_rise |=> !vb_rise);
endmodule

// File: rtl/sal_update_ctrl.sv
module sal_update_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic lock_wr,
  input  logic lock_din,
  input  logic vb_rise,
  output logic lock,
  output logic pending,
  output logic xfer
);
  // The transfer uses the lock as registered, not the value being written.
  assign xfer = vb_rise & pending & ~lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock    <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (lock_wr) lock <= lock_din;
      // A new arm outranks the clear caused by a simultaneous transfer.
      if (arm)       pending <= 1'b1;
      else if (xfer) pending <= 1'b0;
    end
  end

  assert_lock_keeps_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && lock) |=> pending);
  assert_arm_sets_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> pending);
endmodule

// File: rtl/sal_addr_pair.sv
module sal_addr_pair #(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [HALF_W-1:0]   wr_data,
  input  logic                xfer,
  output logic [HALF_W-1:0]   stg_lo,
  output logic [HALF_W-1:0]   stg_hi,
  output logic [2*HALF_W-1:0] active
);
  function automatic logic [2*HALF_W-1:0] join_halves(input logic [HALF_W-1:0] hi,
                                                      input logic [HALF_W-1:0] lo);
    return {hi, lo};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_lo <= '0;
      stg_hi <= '0;
      active <= '0;
    end else begin
      if (wr_lo) stg_lo <= wr_data;
      if (wr_hi) stg_hi <= wr_data;
      // Copies the values staged before any same-cycle write.
      if (xfer)  active <= join_halves(stg_hi, stg_lo);
    end
  end
endmodule

// File: rtl/scanout_addr_latch.sv
module scanout_addr_latch #(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFS_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              vblank,
  output logic [2*DATA_W-1:0] pri_addr,
  output logic [2*DATA_W-1:0] sec_addr,
  output logic              update_pending
);
  import sal_pkg::*;

  localparam int ADDR_W = 2 * DATA_W;

  logic vb_rise, xfer, arm, lock, lock_wr;
  logic [DATA_W-1:0] stg_lo [NUM_SURF];
  logic [DATA_W-1:0] stg_hi [NUM_SURF];
  logic [ADDR_W-1:0] act    [NUM_SURF];

  function automatic logic hit(input logic en, input logic [OFS_W-1:0] a, input int ofs);
    return en && (a == OFS_W'(ofs));
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_word(input logic lk, input logic pd);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CTRL_LOCK_BIT] = lk;
    w[CTRL_PEND_BIT] = pd;
    return w;
  endfunction

  assign arm     = hit(wr_en, wr_addr, OFS_PRI_LO);
  assign lock_wr = hit(wr_en, wr_addr, OFS_CTRL);

  sal_vblank_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .vblank  (vblank),
    .vb_rise (vb_rise)
  );

  sal_update_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .lock_wr  (lock_wr),
    .lock_din (wr_data[CTRL_LOCK_BIT]),
    .vb_rise  (vb_rise),
    .lock     (lock),
    .pending  (update_pending),
    .xfer     (xfer)
  );

  for (genvar g = 0; g < NUM_SURF; g++) begin : g_surf
    sal_addr_pair #(.HALF_W(DATA_W)) u_pair (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (hit(wr_en, wr_addr, 2 * g)),
      .wr_hi   (hit(wr_en, wr_addr, 2 * g + 1)),
      .wr_data (wr_data),
      .xfer    (xfer),
      .stg_lo  (stg_lo[g]),
      .stg_hi  (stg_hi[g]),
      .active  (act[g])
    );
  end

  assign pri_addr = act[0];
  assign sec_addr = act[1];

  always_comb begin
    rd_data = '0;
    if      (rd_addr == OFS_W'(OFS_PRI_LO)) rd_data = stg_lo[0];
    else if (rd_addr == OFS_W'(OFS_PRI_HI)) rd_data = stg_hi[0];
    else if (rd_addr == OFS_W'(OFS_SEC_LO)) rd_data = stg_lo[1];
    else if (rd_addr == OFS_W'(OFS_SEC_HI)) rd_data = stg_hi[1];
    else if (rd_addr == OFS_W'(OFS_CTRL))   rd_data = ctrl_word(lock, update_pending);
  end

  // Active addresses move only on a transfer.
  assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> ($stable(pri_addr) && $stable(sec_addr)));
  // The lock freezes the visible address.
  assert_lock_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(pri_addr));
  // A transfer with no new arm retires the pending flag.
  assert_pending_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !arm) |=> !update_pending);
  // A staging-only write never raises pending.
  assert_stage_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!update_pending && !arm) |=> !update_pending);
endmodule

// File: tb/sim_scanout_addr_latch.sv
module sim_scanout_addr_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        vblank = 1'b0;
  logic [63:0] pri_addr, sec_addr;
  logic        update_pending;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  scanout_addr_latch u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .vblank(vblank),
    .pri_addr(pri_addr), .sec_addr(sec_addr), .update_pending(update_pending)
  );

  // Behavioural reference model
  logic [31:0] m_reg [4];
  logic [63:0] m_pri, m_sec;
  bit m_lock, m_pend, m_vbprev;

  always @(posedge clk) begin
    bit rise, go;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_reg[i] = 0;
      m_pri = 0; m_sec = 0; m_lock = 0; m_pend = 0; m_vbprev = 0;
    end else begin
      rise = vblank && !m_vbprev;
      go = rise && m_pend && !m_lock;
      if (go) begin
        m_pri = {m_reg[1], m_reg[0]};
        m_sec = {m_reg[3], m_reg[2]};
        m_pend = 0;
      end
      if (wr_en) begin
        if (wr_addr < 4) m_reg[wr_addr] = wr_data;
        if (wr_addr == 0) m_pend = 1;
        if (wr_addr == 4) m_lock = wr_data[0];
      end
      m_vbprev = vblank;
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    if (a < 4) return m_reg[a];
    if (a == 4) return {30'd0, m_pend, m_lock};
    return 32'd0;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // Compare against the model every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R4 model pri", pri_addr, m_pri);
      check("R6 model sec", sec_addr, m_sec);
      check("R3 model pending", {63'd0, update_pending}, {63'd0, m_pend});
      check("R9 model read", {32'd0, rd_data}, {32'd0, m_read(rd_addr)});
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic vb_rise();
    vblank = 0; step();
    vblank = 1; step();
  endtask

  task automatic rd(input logic [2:0] a, input string req, input logic [31:0] exp);
    rd_addr = a; #1;
    check(req, {32'd0, rd_data}, {32'd0, exp});
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    step(); step(); step();
    check("R1 reset pri", pri_addr, 0);
    check("R1 reset sec", sec_addr, 0);
    check("R1 reset pending", {63'd0, update_pending}, 0);
    rst_n = 1; step();
    rd(4, "R1 reset ctrl", 0);

    // R2: staging-only writes
    wr(1, 32'hA1A1_0001);
    wr(2, 32'h5E0C_0002);
    wr(3, 32'h5E0C_0003);
    check("R2 no pending", {63'd0, update_pending}, 0);
    check("R2 pri unchanged", pri_addr, 0);
    vb_rise();
    check("R2 no transfer without arm", pri_addr, 0);
    vblank = 0; step();

    // R3: arm via primary low
    wr(0, 32'hB0B0_0010);
    check("R3 pending set", {63'd0, update_pending}, 1);
    rd(4, "R3 ctrl pending bit", 32'h2);
    check("R5 no mid-frame change", pri_addr, 0);

    // R4 / R6: transfer on rising edge
    vb_rise();
    check("R4 pri loaded", pri_addr, 64'hA1A1_0001_B0B0_0010);
    check("R4 pending cleared", {63'd0, update_pending}, 0);
    check("R6 sec loaded", sec_addr, 64'h5E0C_0003_5E0C_0002);

    // R11: arm while vblank held high
    wr(0, 32'hB0B0_0020);
    step(); step();
    check("R11 no transfer on level", pri_addr, 64'hA1A1_0001_B0B0_0010);
    check("R11 still pending", {63'd0, update_pending}, 1);
    vblank = 0; step();

    // R7: lock defers transfer
    wr(4, 32'h1);
    rd(4, "R9 ctrl lock+pending", 32'h3);
    vb_rise();
    check("R7 locked no transfer", pri_addr, 64'hA1A1_0001_B0B0_0010);
    check("R7 locked pending held", {63'd0, update_pending}, 1);
    vblank = 0; step();
    wr(4, 32'h0);
    step();
    check("R7 release alone no transfer", pri_addr, 64'hA1A1_0001_B0B0_0010);
    vb_rise();
    check("R7 transfer after release", pri_addr, 64'hA1A1_0001_B0B0_0020);
    vblank = 0; step();

    // R8: rewrites coalesce into one transfer
    wr(1, 32'hC3C3_0030);
    wr(0, 32'hC3C3_0031);
    wr(0, 32'hC3C3_0032);
    vb_rise();
    check("R8 newest values", pri_addr, 64'hC3C3_0030_C3C3_0032);
    vblank = 0; step();
    wr(1, 32'hD4D4_0040);
    vb_rise();
    check("R8 single transfer", pri_addr, 64'hC3C3_0030_C3C3_0032);
    check("R8 pending low", {63'd0, update_pending}, 0);
    vblank = 0; step();

    // R9 / R10: readback and unmapped offsets
    rd(0, "R9 pri lo readback", 32'hC3C3_0032);
    rd(1, "R9 pri hi readback", 32'hD4D4_0040);
    rd(3, "R9 sec hi readback", 32'h5E0C_0003);
    rd(5, "R10 unmapped 5", 0);
    rd(6, "R10 unmapped 6", 0);
    rd(7, "R10 unmapped 7", 0);

    // R12: arm on the same clock as an eligible edge
    wr(0, 32'hE5E5_0050);
    vblank = 1; wr_en = 1; wr_addr = 0; wr_data = 32'hE5E5_0051;
    step();
    wr_en = 0;
    check("R12 old staged transferred", pri_addr, 64'hD4D4_0040_E5E5_0050);
    check("R12 pending kept", {63'd0, update_pending}, 1);
    vb_rise();
    check("R12 new value next edge", pri_addr, 64'hD4D4_0040_E5E5_0051);
    vblank = 0; step(); step();

    finish_run();
  end
endmodule